// File: doc/BRIEF.md
# Serial Fast-Command Decoder

This block watches a one-bit command line that is sampled once per clock and splits it into three single-cycle pulses: trigger, chip reset and calibrate. A command always begins with a leading `1`. The bit after it, and sometimes one more bit, select the command: `1` then `1` is a calibrate, `1 0 1` is a reset, and `1 0 0` is a trigger. The decoder cannot know that a leading `1` is a lone trigger until it has seen what follows. For that reason every command, trigger included, leaves the block at one fixed distance from its leading bit. Downstream logic therefore sees trigger timing that does not depend on which command it was.

The bits that make up a command are used up once it is decoded, and the search for the next leading `1` starts on the bit that follows. Zeros between commands are ignored. A synchronous reset drops any command that is partly received.

Top module: `fast_cmd_decoder`

## Requirements
- R1: The sequence `1 0 0` on consecutive samples produces exactly one pulse on `trig_o` and no other pulse.
- R2: The sequence `1 1` on consecutive samples produces exactly one pulse on `cal_o` and no other pulse.
- R3: The sequence `1 0 1` on consecutive samples produces exactly one pulse on `chip_rst_o` and no other pulse.
- R4: When the leading `1` is sampled at rising edge k, the decoded pulse is registered at edge k+2 and stays high until edge k+3. This holds for all three commands.
- R5: All bits of a decoded command are used up, including the third bit of a trigger or reset. A leading `1` may come on the very next sample. For example, `1 1 1 1` gives two calibrates two cycles apart, and `1 1 1 0 0` gives a calibrate followed by a trigger.
- R6: Each pulse lasts exactly one cycle, at most one of the three outputs is high in any cycle, and no two pulses come in adjacent cycles.
- R7: While `srst` is high at an edge, all outputs are low after that edge and any partly received command is discarded. A leading `1` that was sampled before `srst` never produces a pulse.
- R8: A line held at `0` produces no pulse.
- R9: All three outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Serial fast-command line |
| trig_o | output | 1 | One-cycle trigger pulse |
| chip_rst_o | output | 1 | One-cycle reset-command pulse |
| cal_o | output | 1 | One-cycle calibrate pulse |

## Verification
The hardest cases to reach are commands packed so that a new leading `1` lands on the same sample on which a calibrate is still waiting to be emitted, and a synchronous reset that arrives between a leading bit and the bit that decides the command. The driver sends commands back to back with no idle bits: runs of calibrates, and a calibrate directly followed by a trigger. It also sends a lone leading `1` and then raises `srst` on the next cycle. After that it checks that no stray pulse appears and that the next clean command still comes out at its fixed delay.

// File: rtl/fast_cmd_decoder.sv
module fast_cmd_decoder (
  input  logic clk,
  input  logic srst,
  input  logic line_i,
  output logic trig_o,
  output logic chip_rst_o,
  output logic cal_o
);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ONE     = 2'd1,
    ST_ONEZERO = 2'd2,
    ST_CALPEND = 2'd3
  } state_t;

  state_t st;

  always_ff @(posedge clk) begin
    if (srst) begin
      st         <= ST_IDLE;
      trig_o     <= 1'b0;
      chip_rst_o <= 1'b0;
      cal_o      <= 1'b0;
    end else begin
      trig_o     <= 1'b0;
      chip_rst_o <= 1'b0;
      cal_o      <= 1'b0;
      case (st)
        ST_IDLE:    st <= line_i ? ST_ONE : ST_IDLE;
        ST_ONE:     st <= line_i ? ST_CALPEND : ST_ONEZERO;
        ST_ONEZERO: begin
          st <= ST_IDLE;
          if (line_i) chip_rst_o <= 1'b1;
          else        trig_o     <= 1'b1;
        end
        default: begin
          cal_o <= 1'b1;
          st    <= line_i ? ST_ONE : ST_IDLE;
        end
      endcase
    end
  end

  assert_onehot_pulses_R6: assert property (@(posedge clk) disable iff (srst)
    $onehot0({trig_o, chip_rst_o, cal_o}));

  assert_pulse_single_cycle_R6: assert property (@(posedge clk) disable iff (srst)
    (trig_o || chip_rst_o || cal_o) |=> !(trig_o || chip_rst_o || cal_o));

  assert_trig_origin_R1: assert property (@(posedge clk) disable iff (srst)
    trig_o |-> ($past(line_i, 3) && !$past(line_i, 2) && !$past(line_i, 1)));

  assert_rst_origin_R3: assert property (@(posedge clk) disable iff (srst)
    chip_rst_o |-> ($past(line_i, 3) && !$past(line_i, 2) && $past(line_i, 1)));

  assert_cal_origin_R2: assert property (@(posedge clk) disable iff (srst)
    cal_o |-> ($past(line_i, 3) && $past(line_i, 2)));

  assert_srst_clears_R7: assert property (@(posedge clk)
    srst |=> !(trig_o || chip_rst_o || cal_o));

endmodule

// File: tb/test_fast_cmd_decoder.sv
module test_fast_cmd_decoder;
  logic clk = 1'b0;
  logic srst = 1'b1;
  logic line_i = 1'b0;
  logic trig_o, chip_rst_o, cal_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int kind; int due; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fast_cmd_decoder i_fast_cmd_decoder (
    .clk(clk), .srst(srst), .line_i(line_i),
    .trig_o(trig_o), .chip_rst_o(chip_rst_o), .cal_o(cal_o)
  );

  function automatic string req_of(int k);
    return (k == 0) ? "R1" : (k == 1) ? "R3" : "R2";
  endfunction

  // kind 0 = trigger, 1 = reset, 2 = calibrate
  task automatic send_cmd(int kind);
    exp_t e;
    @(negedge clk); line_i = 1'b1;
    e.kind = kind; e.due = cyc + 3;  // R4: lead sampled at cyc+1, pulse seen after edge cyc+3
    q.push_back(e);
    @(negedge clk); line_i = (kind == 2);
    if (kind != 2) begin
      @(negedge clk); line_i = (kind == 1);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    int got;
    got = trig_o ? 0 : chip_rst_o ? 1 : cal_o ? 2 : -1;
    if (!srst && (trig_o + chip_rst_o + cal_o) > 1) begin
      checks++; errors++;
      $display("FAIL R6: several pulses at cycle %0d actual=%b%b%b expected=one-hot",
               cyc, trig_o, chip_rst_o, cal_o);
    end
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (got != e.kind) begin
        errors++;
        $display("FAIL %s R4 R5: cycle %0d actual kind=%0d expected kind=%0d",
                 req_of(e.kind), cyc, got, e.kind);
      end
    end else if (got != -1 && !srst) begin
      checks++; errors++;
      $display("FAIL R6 R7 R8: unexpected pulse kind=%0d at cycle %0d expected none", got, cyc);
    end
  end

  task automatic check_quiet(string req);
    checks++;
    if (trig_o || chip_rst_o || cal_o) begin
      errors++;
      $display("FAIL %s: outputs actual=%b%b%b expected=000", req, trig_o, chip_rst_o, cal_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R9");
    srst = 1'b0;
    idle(6);                       // R8: idle line
    check_quiet("R8");
    send_cmd(0); idle(3);          // R1
    send_cmd(2); idle(3);          // R2
    send_cmd(1); idle(3);          // R3
    send_cmd(2); send_cmd(2); send_cmd(2);  // R5 back-to-back calibrates
    send_cmd(2); send_cmd(0);      // R5 calibrate then trigger
    send_cmd(0); send_cmd(1);      // R5 trigger then reset
    send_cmd(1); send_cmd(2); send_cmd(0); idle(4);
    // R7: leading 1 then srst, no pulse
    @(negedge clk); line_i = 1'b1;
    @(negedge clk); line_i = 1'b1; srst = 1'b1;
    @(negedge clk); line_i = 1'b0; srst = 1'b0;
    idle(5);
    check_quiet("R7");
    // R7: srst during decision of a reset pattern
    @(negedge clk); line_i = 1'b1;
    @(negedge clk); line_i = 1'b0;
    @(negedge clk); line_i = 1'b1; srst = 1'b1;
    @(negedge clk); line_i = 1'b0; srst = 1'b0;
    idle(5);
    check_quiet("R7");
    send_cmd(0); idle(4);          // R4 timing intact after reset
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d expected pulses missing, expected 0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule